// File: doc/BRIEF.md
# Compressed-Instruction Branch and Exception Unit

This block resolves control flow for a 16-bit compressed instruction set. For each valid instruction it decides whether the program counter is redirected, computes the redirect address, produces any link-register write, tracks the instruction-set state bit, and raises exception entries. It covers five instruction kinds: the conditional branch, the unconditional short branch, the two halves of the split branch-with-link, the register branch that can switch instruction set, and the software interrupt. It also handles entry into a hardware interrupt.

The surrounding core supplies the instruction word and the program counter. The program counter is the instruction address plus 4. The core also supplies the NZCV flags, one source register value, the current link value, the interrupt line and its mask. Every result appears one clock after the instruction is presented and is held for exactly that cycle. The core uses the flush pulse to discard its fetch stream, and it writes the link register and enters the requested exception mode itself.

The branch-with-link is split in two. The first half stores a partial target in the link register. The second half adds its own low offset to that link value and then replaces the link with the return address.

Top module: `cbr_unit`

## Requirements
- R1: In the cycle after a synchronous reset, flush, link write and exception request are all 0, the new PC, link data and vector are 0, and the state bit is 1.
- R2: A conditional branch has top nibble 1101. It carries a condition in bits 11:8 and a signed 8-bit displacement in bits 7:0. It is taken when the condition holds for flags {N,Z,C,V}. The conditions are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V). When taken, the new PC is PC + displacement*2.
- R3: A conditional branch with condition 1110 is never taken and produces no output activity.
- R4: An instruction with upper byte 0xDF is a software interrupt. It flushes, requests an exception with mode code 01, vectors to 0x08, writes PC-2 to the link register and clears the state bit.
- R5: An instruction with top five bits 11100 branches to PC + sign-extended bits 10:0 times 2.
- R6: An instruction with top five bits 11110 writes PC + (sign-extended bits 10:0 << 12) into the link register. It does not flush.
- R7: An instruction with top five bits 11111 branches to the link input + bits 10:0 times 2, with bit 0 cleared. It writes (PC-2) with bit 0 set into the link register.
- R8: An instruction with bits 15:7 equal to 010001110 branches to the source value with bit 0 cleared. It loads the state bit from bit 0 of the source value.
- R9: When an instruction is valid, the interrupt line is high and the mask is clear, the interrupt takes priority over the instruction. The block flushes, requests mode code 10 at vector 0x18, writes PC+2 to the link register and clears the state bit.
- R10: A masked interrupt has no effect, and the instruction executes as if no interrupt were pending.
- R11: Flush, link write and exception request are high only in the cycle after a valid instruction that causes them. Without valid, and for instructions outside R2 to R8, they stay low.
- R12: Every output changes exactly one clock after the instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction presented this cycle |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 32 | Instruction address plus 4 |
| flags_i | input | 4 | Flags {N,Z,C,V} |
| src_i | input | 32 | Source register value for register branch |
| lr_i | input | 32 | Current link register value |
| irq_i | input | 1 | Interrupt line |
| irq_mask_i | input | 1 | Interrupt mask (1 blocks) |
| flush_o | output | 1 | Redirect pulse |
| new_pc_o | output | 32 | Redirect address |
| lr_we_o | output | 1 | Link register write enable |
| lr_data_o | output | 32 | Link register write value |
| state_o | output | 1 | Instruction-set state (1 = compressed) |
| exc_o | output | 1 | Exception entry request |
| exc_vec_o | output | 32 | Exception vector address |
| exc_mode_o | output | 2 | Requested mode: 01 supervisor, 10 interrupt |

## Verification
An interrupt can arrive in the same cycle as any instruction, including a branch, the software interrupt or either half of the branch-with-link. The bench sweeps every upper-byte value with the interrupt line raised, once unmasked and once masked. The unmasked pass must show interrupt entry with PC+2 in the link register and no trace of the instruction. The masked pass must show exactly the instruction's own result, compared against an arithmetic model of R2 to R8.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_BCOND,
    OP_SWI,
    OP_BSHORT,
    OP_BLHI,
    OP_BLLO,
    OP_BX
  } op_e;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_SVC  = 2'b01,
    MODE_IRQ  = 2'b10
  } mode_e;

  localparam int COND_W  = 4;
  localparam int COND_N  = 1 << COND_W;
  localparam int INSTR_W = 16;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output op_e                op,
  output logic [COND_W-1:0]  cond
);
  assign cond = instr[11:8];

  always_comb begin
    op = OP_NONE;
    if (instr[15:8] == 8'hDF)                op = OP_SWI;
    else if (instr[15:12] == 4'b1101)        op = OP_BCOND;
    else if (instr[15:11] == 5'b11100)       op = OP_BSHORT;
    else if (instr[15:11] == 5'b11110)       op = OP_BLHI;
    else if (instr[15:11] == 5'b11111)       op = OP_BLLO;
    else if (instr[15:7] == 9'b010001110)    op = OP_BX;
  end
endmodule

// File: rtl/cbr_cond.sv
module cbr_cond
  import cbr_pkg::*;
(
  input  logic [3:0]        flags,
  input  logic [COND_W-1:0] cond,
  output logic              pass
);
  logic n, z, c, v;
  assign {n, z, c, v} = flags;

  logic [COND_N-1:0] table_q;

  genvar k;
  generate
    for (k = 0; k < COND_N; k++) begin : g_code
      always_comb begin
        case (k)
          0:  table_q[k] = z;
          1:  table_q[k] = !z;
          2:  table_q[k] = c;
          3:  table_q[k] = !c;
          4:  table_q[k] = n;
          5:  table_q[k] = !n;
          6:  table_q[k] = v;
          7:  table_q[k] = !v;
          8:  table_q[k] = c && !z;
          9:  table_q[k] = !c || z;
          10: table_q[k] = (n == v);
          11: table_q[k] = (n != v);
          12: table_q[k] = !z && (n == v);
          13: table_q[k] = z || (n != v);
          default: table_q[k] = 1'b0;
        endcase
      end
    end
  endgenerate

  assign pass = table_q[cond];
endmodule

// File: rtl/cbr_target.sv
module cbr_target
  import cbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    src,
  input  logic [XLEN-1:0]    lr,
  output logic [XLEN-1:0]    bcond_tgt,
  output logic [XLEN-1:0]    bshort_tgt,
  output logic [XLEN-1:0]    blhi_lr,
  output logic [XLEN-1:0]    bllo_tgt,
  output logic [XLEN-1:0]    bllo_lr,
  output logic [XLEN-1:0]    bx_tgt,
  output logic [XLEN-1:0]    swi_lr,
  output logic [XLEN-1:0]    irq_lr
);
  logic [XLEN-1:0] off8, off11, hi11, lo11;
  logic [XLEN-1:0] next_addr;

  assign off8  = {{(XLEN-9){instr[7]}}, instr[7:0], 1'b0};
  assign off11 = {{(XLEN-12){instr[10]}}, instr[10:0], 1'b0};
  assign hi11  = {{(XLEN-23){instr[10]}}, instr[10:0], 12'b0};
  assign lo11  = {{(XLEN-12){1'b0}}, instr[10:0], 1'b0};

  assign next_addr  = pc - XLEN'(2);
  assign bcond_tgt  = pc + off8;
  assign bshort_tgt = pc + off11;
  assign blhi_lr    = pc + hi11;
  assign bllo_tgt   = (lr + lo11) & ~XLEN'(1);
  assign bllo_lr    = next_addr | XLEN'(1);
  assign bx_tgt     = src & ~XLEN'(1);
  assign swi_lr     = next_addr;
  assign irq_lr     = pc + XLEN'(2);
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] SWI_VEC = 32'h0000_0008,
  parameter logic [31:0] IRQ_VEC = 32'h0000_0018
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [15:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [3:0]      flags_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic            irq_i,
  input  logic            irq_mask_i,
  output logic            flush_o,
  output logic [XLEN-1:0] new_pc_o,
  output logic            lr_we_o,
  output logic [XLEN-1:0] lr_data_o,
  output logic            state_o,
  output logic            exc_o,
  output logic [XLEN-1:0] exc_vec_o,
  output logic [1:0]      exc_mode_o
);
  op_e             op;
  logic [COND_W-1:0] cond;
  logic            pass;
  logic [XLEN-1:0] bcond_tgt, bshort_tgt, blhi_lr, bllo_tgt, bllo_lr;
  logic [XLEN-1:0] bx_tgt, swi_lr, irq_lr;

  cbr_decode u_dec (.instr(instr_i), .op(op), .cond(cond));
  cbr_cond   u_cnd (.flags(flags_i), .cond(cond), .pass(pass));
  cbr_target #(.XLEN(XLEN)) u_tgt (
    .instr(instr_i), .pc(pc_i), .src(src_i), .lr(lr_i),
    .bcond_tgt(bcond_tgt), .bshort_tgt(bshort_tgt), .blhi_lr(blhi_lr),
    .bllo_tgt(bllo_tgt), .bllo_lr(bllo_lr), .bx_tgt(bx_tgt),
    .swi_lr(swi_lr), .irq_lr(irq_lr)
  );

  logic            n_flush, n_lrwe, n_exc, n_state;
  logic [XLEN-1:0] n_pc, n_lr, n_vec;
  mode_e           n_mode;
  logic            irq_take;

  assign irq_take = valid_i && irq_i && !irq_mask_i;

  always_comb begin
    n_flush = 1'b0;
    n_lrwe  = 1'b0;
    n_exc   = 1'b0;
    n_state = state_o;
    n_pc    = '0;
    n_lr    = '0;
    n_vec   = '0;
    n_mode  = MODE_NONE;
    if (irq_take) begin
      n_flush = 1'b1;
      n_exc   = 1'b1;
      n_lrwe  = 1'b1;
      n_lr    = irq_lr;
      n_vec   = XLEN'(IRQ_VEC);
      n_pc    = XLEN'(IRQ_VEC);
      n_mode  = MODE_IRQ;
      n_state = 1'b0;
    end else if (valid_i) begin
      case (op)
        OP_BCOND: if (pass) begin
          n_flush = 1'b1;
          n_pc    = bcond_tgt;
        end
        OP_SWI: begin
          n_flush = 1'b1;
          n_exc   = 1'b1;
          n_lrwe  = 1'b1;
          n_lr    = swi_lr;
          n_vec   = XLEN'(SWI_VEC);
          n_pc    = XLEN'(SWI_VEC);
          n_mode  = MODE_SVC;
          n_state = 1'b0;
        end
        OP_BSHORT: begin
          n_flush = 1'b1;
          n_pc    = bshort_tgt;
        end
        OP_BLHI: begin
          n_lrwe = 1'b1;
          n_lr   = blhi_lr;
        end
        OP_BLLO: begin
          n_flush = 1'b1;
          n_pc    = bllo_tgt;
          n_lrwe  = 1'b1;
          n_lr    = bllo_lr;
        end
        OP_BX: begin
          n_flush = 1'b1;
          n_pc    = bx_tgt;
          n_state = src_i[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_o    <= 1'b0;
      new_pc_o   <= '0;
      lr_we_o    <= 1'b0;
      lr_data_o  <= '0;
      state_o    <= 1'b1;
      exc_o      <= 1'b0;
      exc_vec_o  <= '0;
      exc_mode_o <= MODE_NONE;
    end else begin
      flush_o    <= n_flush;
      new_pc_o   <= n_pc;
      lr_we_o    <= n_lrwe;
      lr_data_o  <= n_lr;
      state_o    <= n_state;
      exc_o      <= n_exc;
      exc_vec_o  <= n_vec;
      exc_mode_o <= n_mode;
    end
  end

  assert_exc_flush_R4: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> flush_o);
  assert_exc_state_R9: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> !state_o);
  assert_mode_match_R4: assert property (@(posedge clk) disable iff (rst)
    (exc_mode_o != 2'b00) == exc_o);
  assert_pc_even_R8: assert property (@(posedge clk) disable iff (rst)
    flush_o && !exc_o |-> new_pc_o[0] == 1'b0);
  assert_irq_entry_R9: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> exc_o && exc_mode_o == 2'b10 && lr_we_o);
  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !flush_o && !lr_we_o && !exc_o);
  assert_state_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(state_o));
endmodule

// File: tb/sim_cbr_unit.sv
module sim_cbr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [31:0] pc_i = '0, src_i = '0, lr_i = '0;
  logic [3:0]  flags_i = '0;
  logic        irq_i = 1'b0, irq_mask_i = 1'b0;
  logic        flush_o, lr_we_o, state_o, exc_o;
  logic [31:0] new_pc_o, lr_data_o, exc_vec_o;
  logic [1:0]  exc_mode_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic st_model = 1'b1;

  always #10 clk = ~clk;

  cbr_unit u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
    .flags_i(flags_i), .src_i(src_i), .lr_i(lr_i), .irq_i(irq_i),
    .irq_mask_i(irq_mask_i), .flush_o(flush_o), .new_pc_o(new_pc_o),
    .lr_we_o(lr_we_o), .lr_data_o(lr_data_o), .state_o(state_o),
    .exc_o(exc_o), .exc_vec_o(exc_vec_o), .exc_mode_o(exc_mode_o)
  );

  function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cc, v;
    {n, z, cc, v} = f;
    case (c)
      0: return z;            1: return !z;
      2: return cc;           3: return !cc;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return cc && !z;     9: return !cc || z;
      10: return n == v;      11: return n != v;
      12: return !z && n == v;
      13: return z || n != v;
      default: return 0;
    endcase
  endfunction

  logic [138:0] exp_v;
  logic [138:0] got_v;

  task automatic model(output logic [138:0] e);
    logic f, w, x; logic [31:0] p, l, vc; logic [1:0] m;
    int s8, s11;
    f = 0; w = 0; x = 0; p = 0; l = 0; vc = 0; m = 0;
    s8  = $signed(instr_i[7:0]);
    s11 = $signed(instr_i[10:0]);
    if (valid_i && irq_i && !irq_mask_i) begin
      f = 1; x = 1; w = 1; l = pc_i + 2; vc = 32'h18; p = 32'h18; m = 2'b10; st_model = 0;
    end else if (valid_i) begin
      if (instr_i[15:8] == 8'hDF) begin
        f = 1; x = 1; w = 1; l = pc_i - 2; vc = 32'h8; p = 32'h8; m = 2'b01; st_model = 0;
      end else if (instr_i[15:12] == 4'hD) begin
        if (cond_ok(instr_i[11:8], flags_i)) begin f = 1; p = pc_i + 32'(s8 * 2); end
      end else if (instr_i[15:11] == 5'b11100) begin
        f = 1; p = pc_i + 32'(s11 * 2);
      end else if (instr_i[15:11] == 5'b11110) begin
        w = 1; l = pc_i + 32'(s11 * 4096);
      end else if (instr_i[15:11] == 5'b11111) begin
        f = 1; p = (lr_i + 32'(instr_i[10:0]) * 2) & ~32'd1; w = 1; l = (pc_i - 2) | 1;
      end else if (instr_i[15:7] == 9'b010001110) begin
        f = 1; p = {src_i[31:1], 1'b0}; st_model = src_i[0];
      end
    end
    e = {f, p, w, l, st_model, x, vc, m};
  endtask

  task automatic step(input string tag);
    model(exp_v);
    @(negedge clk);
    got_v = {flush_o, new_pc_o, lr_we_o, lr_data_o, state_o, exc_o, exc_vec_o, exc_mode_o};
    checks++;
    if (got_v !== exp_v) begin
      fails++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag, instr_i, got_v, exp_v);
    end
  endtask

  task automatic drive(input logic [15:0] ins, input logic [31:0] pc, input string tag);
    valid_i = 1; instr_i = ins; pc_i = pc;
    step(tag);
  endtask

  task automatic idle_check(input string tag);
    valid_i = 0;
    step(tag);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if ({flush_o, lr_we_o, exc_o, state_o, new_pc_o, lr_data_o, exc_vec_o} !== {3'b000, 1'b1, 96'd0}) begin
      fails++; $display("FAIL R1 actual=%b expected=0001", {flush_o, lr_we_o, exc_o, state_o});
    end
    rst = 0;
    // R2/R3: every condition against every flag value
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        if (c == 15) continue;
        flags_i = 4'(f);
        drive({4'hD, 4'(c), 8'h85}, 32'h0000_4000 + 32'(f * 16), c == 14 ? "R3" : "R2");
      end
    // R2: displacement sweep
    flags_i = 4'b0100;
    for (int d = 0; d < 256; d++) drive({8'hD0, 8'(d)}, 32'h0001_0000, "R2");
    // R11/R12: single-cycle flush after a taken branch
    drive(16'hE005, 32'h100, "R5");
    idle_check("R11");
    // R5 short branch sweep
    for (int d = 0; d < 2048; d++) drive({5'b11100, 11'(d)}, 32'h0002_0000, "R5");
    // R6 prefix sweep
    for (int d = 0; d < 2048; d++) drive({5'b11110, 11'(d)}, 32'h0080_0004, "R6");
    // R7 suffix sweep, odd link input exercises bit-0 clearing
    for (int d = 0; d < 2048; d++) begin
      lr_i = 32'h0040_0001 + 32'(d * 8);
      drive({5'b11111, 11'(d)}, 32'h0000_0204, "R7");
    end
    // R8 register branch, both state outcomes
    for (int k = 0; k < 16; k++) begin
      src_i = 32'h1234_5670 + 32'(k);
      drive({9'b010001110, 4'(k), 3'b000}, 32'h300, "R8");
    end
    // R4 software interrupt
    drive(16'hDF42, 32'h0000_0A04, "R4");
    idle_check("R11");
    // R9/R10: interrupt alongside every upper-byte value
    flags_i = 4'b0110;
    src_i = 32'h0000_0201;
    lr_i = 32'h0000_1000;
    irq_i = 1;
    for (int m = 0; m < 2; m++) begin
      irq_mask_i = 1'(m);
      for (int b = 0; b < 256; b++)
        drive({8'(b), 8'h3C}, 32'h0000_8000 + 32'(b * 4), m == 0 ? "R9" : "R10");
    end
    // R11: interrupt without valid is not taken
    irq_mask_i = 0;
    idle_check("R11");
    irq_i = 0;
    // R11: non-control instructions leave outputs quiet
    for (int b = 0; b < 256; b++) drive({8'(b), 8'hA7}, 32'h0000_C000, "R11");
    // R1 again: reset mid-stream restores state bit
    valid_i = 0;
    rst = 1;
    @(negedge clk);
    checks++;
    if (state_o !== 1'b1 || flush_o !== 1'b0) begin
      fails++; $display("FAIL R1 actual=%b%b expected=10", state_o, flush_o);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule